// File: doc/BRIEF.md
# Macroblock Motion Search Cost Tree with Early Skip

This block computes sum-of-absolute-difference (SAD) matching costs between a 16x16 luma macroblock and a series of integer-displaced reference candidates. Each candidate arrives as sixteen pixel rows, one per valid cycle, with the current-block row and the reference row presented side by side. Only the sixteen 4x4 SADs are accumulated from pixels. Every larger partition cost (8x4, 4x8, 8x8, 16x8, 8x16, 16x16) is formed by an adder tree over those sixteen values, so there is no second pass over the pixels.

For every one of the 41 partitions the block keeps the lowest cost seen since the start of the macroblock and the motion vector that produced it. A selector port reads any partition's result. An early-exit test runs on the first candidate of each macroblock. If that candidate has zero displacement and its 16x16 cost is below a programmable threshold, a sticky skip flag rises. The remaining search for that macroblock then has no effect on the stored results.

A macroblock begins with a start pulse. Candidates may follow back to back. The threshold is loaded through a one-cycle configuration write.

Top module: `msad_tree_top`

## Requirements
- R1: After reset, skip_o is 0, cand_done_o is 0, and every partition reads cost 16'hFFFF with both vector components 0.
- R2: Pixel x of a row occupies bits [8x+7:8x], and row y of the candidate is the y-th valid row. Partition index 25+4*r+c (r,c in 0..3) holds the 4x4 block at pixel rows 4r..4r+3 and columns 4c..4c+3.
- R3: The larger partitions use these indices. 0 is 16x16. 1+h is the 16-wide, 8-tall half at rows 8h. 3+h is the 8-wide, 16-tall half at columns 8h. 5+q is the 8x8 quadrant q, where q = 2*row_half + col_half. 9+2q+h is the 8-wide, 4-tall half h (top then bottom) of quadrant q. 17+2q+h is the 4-wide, 8-tall half h (left then right) of quadrant q. Each cost equals the SAD over its pixels.
- R4: When a candidate completes and no skip is active, each partition whose new cost is strictly lower than its stored minimum takes that cost and the candidate's vector. The vector components are signed 5-bit values.
- R5: A candidate whose cost equals the stored minimum leaves that partition's cost and vector unchanged.
- R6: If the first candidate after mb_start_i (or after reset) has vector (0,0) and a 16x16 cost strictly below the threshold, skip_o rises together with the result update. It then stays high until the next mb_start_i.
- R7: A (0,0) first candidate whose 16x16 cost equals the threshold leaves skip_o at 0.
- R8: While skip_o is high, completed candidates change no stored cost or vector.
- R9: A first candidate with a nonzero vector does not raise skip_o, and neither does a later (0,0) candidate.
- R10: mb_start_i restores every partition to cost 16'hFFFF and vector 0, and clears skip_o, from the following cycle.
- R11: cand_done_o is high for exactly the one cycle after the 16th row of a candidate is accepted. The updated results are readable from the cycle after that.
- R12: Costs use the full range without wrap. With all current pixels 255 and all reference pixels 0, a 4x4 cost reads 4080 and the 16x16 cost reads 65280.
- R13: A selector value of 41 or above reads cost 16'hFFFF and vector 0.
- R14: cfg_we_i loads cfg_thr_i into the threshold. The threshold resets to 0, so no candidate can raise skip_o before the first write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Threshold write strobe |
| cfg_thr_i | input | 16 | Threshold value |
| mb_start_i | input | 1 | Start of a new macroblock; clears results |
| row_vld_i | input | 1 | Current and reference rows are valid |
| cur_row_i | input | 128 | Sixteen 8-bit current-block pixels |
| ref_row_i | input | 128 | Sixteen 8-bit reference pixels |
| cand_mvx_i | input | 5 | Candidate horizontal displacement, signed |
| cand_mvy_i | input | 5 | Candidate vertical displacement, signed |
| sel_part_i | input | 6 | Partition selector for the result port |
| cand_done_o | output | 1 | One-cycle pulse after a candidate's last row |
| skip_o | output | 1 | Early-skip flag for the current macroblock |
| res_cost_o | output | 16 | Minimum cost of the selected partition |
| res_mvx_o | output | 5 | Horizontal vector of that minimum |
| res_mvy_o | output | 5 | Vertical vector of that minimum |

## Verification
If a 4x4 accumulator is wrongly cleared or carried over, the fault shows up on the result port the cycle after cand_done_o. It appears in that block's own cost and in every larger partition that contains the block. Comparing the reference-free tree sums against direct pixel sums therefore localizes the fault. A wrong first-candidate or skip state shows either as a skip_o change in the update cycle or as minima that keep moving after skip. Both are visible within one candidate. A comparison that does not treat ties strictly shows only as a changed vector on equal-cost candidates, so the vectors are checked as well as the costs.

// File: rtl/msad_pkg.sv
package msad_pkg;
  localparam int PIX_W   = 8;
  localparam int MB_DIM  = 16;
  localparam int BLK_DIM = 4;
  localparam int COST_W  = 16;
  localparam int MV_W    = 5;
  localparam int N_PART  = 41;
  // partition index bases; the result selector decodes these
  localparam int PI_16X16 = 0;
  localparam int PI_16X8  = 1;
  localparam int PI_8X16  = 3;
  localparam int PI_8X8   = 5;
  localparam int PI_8X4   = 9;
  localparam int PI_4X8   = 17;
  localparam int PI_4X4   = 25;
endpackage

// File: rtl/msad_row_unit.sv
module msad_row_unit #(
  parameter int PIX_W   = 8,
  parameter int MB_DIM  = 16,
  parameter int BLK_DIM = 4,
  localparam int NSEG   = MB_DIM / BLK_DIM,
  localparam int SEG_W  = PIX_W + $clog2(BLK_DIM)
) (
  input  logic [MB_DIM*PIX_W-1:0] cur_row_i,
  input  logic [MB_DIM*PIX_W-1:0] ref_row_i,
  output logic [NSEG*SEG_W-1:0]   seg_sum_o
);

  function automatic logic [PIX_W-1:0] absdiff(input logic [PIX_W-1:0] a,
                                               input logic [PIX_W-1:0] b);
    return (a > b) ? (a - b) : (b - a);
  endfunction

  // one horizontal 4-pixel segment per 4x4 block column
  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    logic [SEG_W-1:0] seg_acc;
    always_comb begin
      seg_acc = '0;
      for (int k = 0; k < BLK_DIM; k++) begin
        seg_acc = seg_acc + SEG_W'(absdiff(cur_row_i[(s*BLK_DIM+k)*PIX_W +: PIX_W],
                                           ref_row_i[(s*BLK_DIM+k)*PIX_W +: PIX_W]));
      end
    end
    assign seg_sum_o[s*SEG_W +: SEG_W] = seg_acc;
  end

endmodule

// File: rtl/msad_blk_accum.sv
module msad_blk_accum #(
  parameter int MB_DIM  = 16,
  parameter int BLK_DIM = 4,
  parameter int SEG_W   = 10,
  parameter int ACC_W   = 12,
  parameter int TAG_W   = 10,
  localparam int NSEG   = MB_DIM / BLK_DIM,
  localparam int NBLK   = NSEG * NSEG,
  localparam int ROW_W  = $clog2(MB_DIM),
  localparam int SUB_W  = $clog2(BLK_DIM)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   mb_start_i,
  input  logic                   row_vld_i,
  input  logic [NSEG*SEG_W-1:0]  seg_sum_i,
  input  logic [TAG_W-1:0]       tag_i,
  output logic [NBLK*ACC_W-1:0]  blk_sad_o,
  output logic [TAG_W-1:0]       tag_o,
  output logic                   eval_o
);

  logic [ROW_W-1:0] cnt_q, cnt_d, row_idx;
  logic [ACC_W-1:0] acc_q [NBLK];
  logic [ACC_W-1:0] acc_d [NBLK];
  logic [TAG_W-1:0] tag_q, tag_d;
  logic             eval_q, eval_d;

  always_comb begin
    row_idx = mb_start_i ? '0 : cnt_q;
    cnt_d   = row_idx;
    if (row_vld_i) begin
      cnt_d = (row_idx == ROW_W'(MB_DIM-1)) ? '0 : row_idx + ROW_W'(1);
    end
    eval_d = row_vld_i && (row_idx == ROW_W'(MB_DIM-1));
    tag_d  = eval_d ? tag_i : tag_q;
    for (int b = 0; b < NBLK; b++) begin
      acc_d[b] = acc_q[b];
      if (row_vld_i && (row_idx[ROW_W-1:SUB_W] == (ROW_W-SUB_W)'(b / NSEG))) begin
        if (row_idx[SUB_W-1:0] == '0) begin
          acc_d[b] = ACC_W'(seg_sum_i[(b % NSEG)*SEG_W +: SEG_W]);
        end else begin
          acc_d[b] = acc_q[b] + ACC_W'(seg_sum_i[(b % NSEG)*SEG_W +: SEG_W]);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      eval_q <= 1'b0;
      tag_q  <= '0;
      for (int b = 0; b < NBLK; b++) acc_q[b] <= '0;
    end else begin
      eval_q <= eval_d;
      if (row_vld_i || mb_start_i) cnt_q <= cnt_d;
      if (eval_d) tag_q <= tag_d;
      if (row_vld_i) begin
        for (int b = 0; b < NBLK; b++) acc_q[b] <= acc_d[b];
      end
    end
  end

  for (genvar b = 0; b < NBLK; b++) begin : g_out
    assign blk_sad_o[b*ACC_W +: ACC_W] = acc_q[b];
  end
  assign tag_o  = tag_q;
  assign eval_o = eval_q;

  // R11: the done pulse only follows an accepted row and lasts one cycle
  a_r11_eval_after_row: assert property (@(posedge clk) disable iff (!rst_n)
    eval_q |-> $past(row_vld_i));
  a_r11_eval_single: assert property (@(posedge clk) disable iff (!rst_n)
    eval_q |=> !eval_q);

endmodule

// File: rtl/msad_part_tree.sv
module msad_part_tree
  import msad_pkg::*;
#(
  parameter int NSIDE   = 4,
  parameter int ACC_W   = 12,
  parameter int COST_W  = 16,
  parameter int NPART   = 41,
  localparam int NBLK   = NSIDE * NSIDE
) (
  input  logic [NBLK*ACC_W-1:0]   blk_sad_i,
  output logic [NPART*COST_W-1:0] part_cost_o
);

  logic [COST_W-1:0] b4   [NBLK];
  logic [COST_W-1:0] h84  [8];
  logic [COST_W-1:0] v48  [8];
  logic [COST_W-1:0] q8   [4];
  logic [COST_W-1:0] h168 [2];
  logic [COST_W-1:0] v816 [2];
  logic [COST_W-1:0] f16;

  for (genvar i = 0; i < NBLK; i++) begin : g_leaf
    assign b4[i] = COST_W'(blk_sad_i[i*ACC_W +: ACC_W]);
    assign part_cost_o[(PI_4X4+i)*COST_W +: COST_W] = b4[i];
  end

  for (genvar q = 0; q < 4; q++) begin : g_quad
    localparam int TL = 2*(q/2)*NSIDE + 2*(q%2);
    assign h84[2*q]   = b4[TL] + b4[TL+1];
    assign h84[2*q+1] = b4[TL+NSIDE] + b4[TL+NSIDE+1];
    assign v48[2*q]   = b4[TL] + b4[TL+NSIDE];
    assign v48[2*q+1] = b4[TL+1] + b4[TL+NSIDE+1];
    assign q8[q]      = h84[2*q] + h84[2*q+1];
    assign part_cost_o[(PI_8X8+q)*COST_W +: COST_W]     = q8[q];
    assign part_cost_o[(PI_8X4+2*q)*COST_W +: COST_W]   = h84[2*q];
    assign part_cost_o[(PI_8X4+2*q+1)*COST_W +: COST_W] = h84[2*q+1];
    assign part_cost_o[(PI_4X8+2*q)*COST_W +: COST_W]   = v48[2*q];
    assign part_cost_o[(PI_4X8+2*q+1)*COST_W +: COST_W] = v48[2*q+1];
  end

  for (genvar h = 0; h < 2; h++) begin : g_half
    assign h168[h] = q8[2*h] + q8[2*h+1];
    assign v816[h] = q8[h] + q8[h+2];
    assign part_cost_o[(PI_16X8+h)*COST_W +: COST_W] = h168[h];
    assign part_cost_o[(PI_8X16+h)*COST_W +: COST_W] = v816[h];
  end

  assign f16 = h168[0] + h168[1];
  assign part_cost_o[PI_16X16*COST_W +: COST_W] = f16;

endmodule

// File: rtl/msad_min_track.sv
module msad_min_track
  import msad_pkg::*;
#(
  parameter int NPART  = 41,
  parameter int COST_W = 16,
  parameter int MV_W   = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    mb_start_i,
  input  logic                    eval_i,
  input  logic [MV_W-1:0]         mvx_i,
  input  logic [MV_W-1:0]         mvy_i,
  input  logic [COST_W-1:0]       thr_i,
  input  logic [NPART*COST_W-1:0] part_cost_i,
  output logic                    skip_o,
  output logic [NPART*COST_W-1:0] min_cost_o,
  output logic [NPART*MV_W-1:0]   min_mvx_o,
  output logic [NPART*MV_W-1:0]   min_mvy_o
);

  logic [COST_W-1:0] cost_q [NPART];
  logic [COST_W-1:0] cost_d [NPART];
  logic [MV_W-1:0]   mvx_q  [NPART];
  logic [MV_W-1:0]   mvx_d  [NPART];
  logic [MV_W-1:0]   mvy_q  [NPART];
  logic [MV_W-1:0]   mvy_d  [NPART];
  logic              skip_q, skip_d, first_q, first_d, zero_hit;

  always_comb begin
    zero_hit = eval_i && first_q && (mvx_i == '0) && (mvy_i == '0) &&
               (part_cost_i[PI_16X16*COST_W +: COST_W] < thr_i);
    skip_d   = mb_start_i ? 1'b0 : (skip_q | zero_hit);
    first_d  = mb_start_i ? 1'b1 : (eval_i ? 1'b0 : first_q);
    for (int i = 0; i < NPART; i++) begin
      cost_d[i] = cost_q[i];
      mvx_d[i]  = mvx_q[i];
      mvy_d[i]  = mvy_q[i];
      if (mb_start_i) begin
        cost_d[i] = '1;
        mvx_d[i]  = '0;
        mvy_d[i]  = '0;
      end else if (eval_i && !skip_q &&
                   (part_cost_i[i*COST_W +: COST_W] < cost_q[i])) begin
        cost_d[i] = part_cost_i[i*COST_W +: COST_W];
        mvx_d[i]  = mvx_i;
        mvy_d[i]  = mvy_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      skip_q  <= 1'b0;
      first_q <= 1'b1;
      for (int i = 0; i < NPART; i++) begin
        cost_q[i] <= '1;
        mvx_q[i]  <= '0;
        mvy_q[i]  <= '0;
      end
    end else if (mb_start_i || eval_i) begin
      skip_q  <= skip_d;
      first_q <= first_d;
      for (int i = 0; i < NPART; i++) begin
        cost_q[i] <= cost_d[i];
        mvx_q[i]  <= mvx_d[i];
        mvy_q[i]  <= mvy_d[i];
      end
    end
  end

  for (genvar i = 0; i < NPART; i++) begin : g_out
    assign min_cost_o[i*COST_W +: COST_W] = cost_q[i];
    assign min_mvx_o[i*MV_W +: MV_W]      = mvx_q[i];
    assign min_mvy_o[i*MV_W +: MV_W]      = mvy_q[i];
  end
  assign skip_o = skip_q;

  // R6: skip is sticky inside a macroblock and only rises on a first-candidate evaluation
  a_r6_skip_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_q && !mb_start_i) |=> skip_q);
  a_r6_skip_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(skip_q) |-> $past(eval_i && first_q));
  // R8: minima frozen under skip
  a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_q && !mb_start_i) |=> $stable(cost_q[PI_16X16]) && $stable(mvx_q[PI_16X16]));
  // R4: the tracked minimum never grows within a macroblock
  a_r4_min_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    !mb_start_i |=> (cost_q[PI_16X16] <= $past(cost_q[PI_16X16])));
  // R10: start of macroblock clears state
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    mb_start_i |=> (!skip_q && (cost_q[PI_16X16] == '1)));

endmodule

// File: rtl/msad_tree_top.sv
module msad_tree_top
  import msad_pkg::*;
#(
  parameter int PIX_W    = msad_pkg::PIX_W,
  parameter int MB_DIM   = msad_pkg::MB_DIM,
  parameter int BLK_DIM  = msad_pkg::BLK_DIM,
  parameter int COST_W   = msad_pkg::COST_W,
  parameter int MV_W     = msad_pkg::MV_W,
  localparam int NSEG    = MB_DIM / BLK_DIM,
  localparam int SEG_W   = PIX_W + $clog2(BLK_DIM),
  localparam int ACC_W   = PIX_W + 2*$clog2(BLK_DIM),
  localparam int SEL_W   = $clog2(N_PART)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we_i,
  input  logic [COST_W-1:0]       cfg_thr_i,
  input  logic                    mb_start_i,
  input  logic                    row_vld_i,
  input  logic [MB_DIM*PIX_W-1:0] cur_row_i,
  input  logic [MB_DIM*PIX_W-1:0] ref_row_i,
  input  logic [MV_W-1:0]         cand_mvx_i,
  input  logic [MV_W-1:0]         cand_mvy_i,
  input  logic [SEL_W-1:0]        sel_part_i,
  output logic                    cand_done_o,
  output logic                    skip_o,
  output logic [COST_W-1:0]       res_cost_o,
  output logic [MV_W-1:0]         res_mvx_o,
  output logic [MV_W-1:0]         res_mvy_o
);

  logic [COST_W-1:0]        thr_q, thr_d;
  logic [NSEG*SEG_W-1:0]    seg_sum;
  logic [NSEG*NSEG*ACC_W-1:0] blk_sad;
  logic [2*MV_W-1:0]        tag_mv;
  logic                     eval;
  logic [N_PART*COST_W-1:0] part_cost, min_cost;
  logic [N_PART*MV_W-1:0]   min_mvx, min_mvy;
  logic [COST_W-1:0]        sel_cost [N_PART];
  logic [MV_W-1:0]          sel_mvx  [N_PART];
  logic [MV_W-1:0]          sel_mvy  [N_PART];

  always_comb thr_d = cfg_we_i ? cfg_thr_i : thr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        thr_q <= '0;
    else if (cfg_we_i) thr_q <= thr_d;
  end

  msad_row_unit #(.PIX_W(PIX_W), .MB_DIM(MB_DIM), .BLK_DIM(BLK_DIM)) row_i (
    .cur_row_i (cur_row_i),
    .ref_row_i (ref_row_i),
    .seg_sum_o (seg_sum)
  );

  msad_blk_accum #(.MB_DIM(MB_DIM), .BLK_DIM(BLK_DIM), .SEG_W(SEG_W),
                   .ACC_W(ACC_W), .TAG_W(2*MV_W)) acc_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .mb_start_i (mb_start_i),
    .row_vld_i  (row_vld_i),
    .seg_sum_i  (seg_sum),
    .tag_i      ({cand_mvx_i, cand_mvy_i}),
    .blk_sad_o  (blk_sad),
    .tag_o      (tag_mv),
    .eval_o     (eval)
  );

  msad_part_tree #(.NSIDE(NSEG), .ACC_W(ACC_W), .COST_W(COST_W), .NPART(N_PART)) tree_i (
    .blk_sad_i   (blk_sad),
    .part_cost_o (part_cost)
  );

  msad_min_track #(.NPART(N_PART), .COST_W(COST_W), .MV_W(MV_W)) trk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .mb_start_i  (mb_start_i),
    .eval_i      (eval),
    .mvx_i       (tag_mv[2*MV_W-1:MV_W]),
    .mvy_i       (tag_mv[MV_W-1:0]),
    .thr_i       (thr_q),
    .part_cost_i (part_cost),
    .skip_o      (skip_o),
    .min_cost_o  (min_cost),
    .min_mvx_o   (min_mvx),
    .min_mvy_o   (min_mvy)
  );

  for (genvar i = 0; i < N_PART; i++) begin : g_sel
    assign sel_cost[i] = min_cost[i*COST_W +: COST_W];
    assign sel_mvx[i]  = min_mvx[i*MV_W +: MV_W];
    assign sel_mvy[i]  = min_mvy[i*MV_W +: MV_W];
  end

  always_comb begin
    res_cost_o = '1;
    res_mvx_o  = '0;
    res_mvy_o  = '0;
    if (sel_part_i < SEL_W'(N_PART)) begin
      res_cost_o = sel_cost[sel_part_i];
      res_mvx_o  = sel_mvx[sel_part_i];
      res_mvy_o  = sel_mvy[sel_part_i];
    end
  end

  assign cand_done_o = eval;

endmodule

// File: tb/msad_tree_top_tb.sv
module msad_tree_top_tb_top;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         cfg_we;
  logic [15:0]  cfg_thr;
  logic         mb_start;
  logic         row_vld;
  logic [127:0] cur_row;
  logic [127:0] ref_row;
  logic [4:0]   mvx, mvy;
  logic [5:0]   sel;
  logic         cand_done, skip;
  logic [15:0]  res_cost;
  logic [4:0]   res_mvx, res_mvy;

  int checks = 0;
  int failures = 0;
  bit cur_max = 0;

  int exp_cost [41];
  int exp_mvx  [41];
  int exp_mvy  [41];
  int exp_skip, exp_first, exp_thr;

  // {new_mb, threshold, mvx, mvy, seed}; seed 255 = reference equals current
  localparam logic [34:0] VEC [8] = '{
    {1'b1, 16'h0000, 5'd0,  5'd0,  8'd3},
    {1'b0, 16'h0000, 5'd1,  5'h1E, 8'd7},
    {1'b0, 16'h0000, 5'h1D, 5'd4,  8'd7},
    {1'b0, 16'h0000, 5'd8,  5'h18, 8'd255},
    {1'b1, 16'hFFFF, 5'd0,  5'd0,  8'd9},
    {1'b0, 16'h0000, 5'd2,  5'd2,  8'd255},
    {1'b1, 16'hFFFF, 5'd3,  5'd1,  8'd255},
    {1'b0, 16'h0000, 5'd0,  5'd0,  8'd5}
  };

  always #5 clk = ~clk;

  msad_tree_top dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we), .cfg_thr_i(cfg_thr),
    .mb_start_i(mb_start), .row_vld_i(row_vld), .cur_row_i(cur_row),
    .ref_row_i(ref_row), .cand_mvx_i(mvx), .cand_mvy_i(mvy), .sel_part_i(sel),
    .cand_done_o(cand_done), .skip_o(skip), .res_cost_o(res_cost),
    .res_mvx_o(res_mvx), .res_mvy_o(res_mvy)
  );

  function automatic int curpx(int x, int y);
    return cur_max ? 255 : ((x*23 + y*41 + 11) & 255);
  endfunction

  function automatic int refpx(int s, int x, int y);
    if (s == 255) return curpx(x, y);
    if (s == 254) return 0;
    return ((x*37 + y*91 + s*53) ^ (s*17 + x*y)) & 255;
  endfunction

  // direct SAD over the pixel rectangle of partition p
  function automatic int part_sad(int p, int s);
    int x0, y0, w, h, q, k, acc, a, b;
    if (p == 0) begin x0 = 0; y0 = 0; w = 16; h = 16; end
    else if (p < 3) begin x0 = 0; y0 = 8*(p-1); w = 16; h = 8; end
    else if (p < 5) begin x0 = 8*(p-3); y0 = 0; w = 8; h = 16; end
    else if (p < 9) begin q = p-5; x0 = 8*(q%2); y0 = 8*(q/2); w = 8; h = 8; end
    else if (p < 17) begin q = (p-9)/2; k = (p-9)%2;
      x0 = 8*(q%2); y0 = 8*(q/2) + 4*k; w = 8; h = 4; end
    else if (p < 25) begin q = (p-17)/2; k = (p-17)%2;
      x0 = 8*(q%2) + 4*k; y0 = 8*(q/2); w = 4; h = 8; end
    else begin k = p-25; x0 = 4*(k%4); y0 = 4*(k/4); w = 4; h = 4; end
    acc = 0;
    for (int y = y0; y < y0+h; y++) begin
      for (int x = x0; x < x0+w; x++) begin
        a = curpx(x, y); b = refpx(s, x, y);
        acc += (a > b) ? a-b : b-a;
      end
    end
    return acc;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic model_clear();
    for (int p = 0; p < 41; p++) begin exp_cost[p] = 65535; exp_mvx[p] = 0; exp_mvy[p] = 0; end
    exp_skip = 0; exp_first = 1;
  endtask

  task automatic model_cand(input logic [4:0] mx, input logic [4:0] my, input int s);
    int c [41];
    int ns;
    for (int p = 0; p < 41; p++) c[p] = part_sad(p, s);
    ns = (exp_first == 1 && mx == 5'd0 && my == 5'd0 && c[0] < exp_thr) ? 1 : 0;
    if (exp_skip == 0) begin
      for (int p = 0; p < 41; p++) begin
        if (c[p] < exp_cost[p]) begin
          exp_cost[p] = c[p]; exp_mvx[p] = int'(mx); exp_mvy[p] = int'(my);
        end
      end
    end
    if (ns == 1) exp_skip = 1;
    exp_first = 0;
  endtask

  task automatic new_mb(input int thr);
    @(negedge clk);
    mb_start = 1'b1; cfg_we = 1'b1; cfg_thr = 16'(thr);
    @(negedge clk);
    mb_start = 1'b0; cfg_we = 1'b0;
    exp_thr = thr;
    model_clear();
  endtask

  task automatic send_cand(input logic [4:0] mx, input logic [4:0] my, input int s);
    for (int y = 0; y < 16; y++) begin
      @(negedge clk);
      row_vld = 1'b1; mvx = mx; mvy = my;
      for (int x = 0; x < 16; x++) begin
        cur_row[x*8 +: 8] = 8'(curpx(x, y));
        ref_row[x*8 +: 8] = 8'(refpx(s, x, y));
      end
    end
    @(negedge clk);
    row_vld = 1'b0;
    chk(cand_done == 1'b1, "R11", "done pulse", int'(cand_done), 1);
    @(negedge clk);
    chk(cand_done == 1'b0, "R11", "done width", int'(cand_done), 0);
    model_cand(mx, my, s);
  endtask

  task automatic check_all(input string req);
    for (int p = 0; p < 41; p++) begin
      @(negedge clk);
      sel = 6'(p);
      #1;
      chk(int'(res_cost) == exp_cost[p], (p >= 25) ? "R2" : "R3",
          $sformatf("cost part %0d (%s)", p, req), int'(res_cost), exp_cost[p]);
      chk(int'(res_mvx) == exp_mvx[p] && int'(res_mvy) == exp_mvy[p], req,
          $sformatf("vector part %0d", p), int'({res_mvx, res_mvy}),
          exp_mvx[p]*32 + exp_mvy[p]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R11 watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
    $finish;
  end

  initial begin
    int s9;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_thr = '0; mb_start = 1'b0; row_vld = 1'b0;
    cur_row = '0; ref_row = '0; mvx = '0; mvy = '0; sel = '0;
    exp_thr = 0;
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(skip == 1'b0, "R1", "skip after reset", int'(skip), 0);
    chk(cand_done == 1'b0, "R1", "done after reset", int'(cand_done), 0);
    chk(res_cost == 16'hFFFF && res_mvx == 5'd0, "R1", "part 0 after reset", int'(res_cost), 65535);
    sel = 6'd40; #1;
    chk(res_cost == 16'hFFFF && res_mvy == 5'd0, "R1", "part 40 after reset", int'(res_cost), 65535);

    // R14: threshold resets to 0, so a perfect (0,0) match cannot skip
    send_cand(5'd0, 5'd0, 255);
    chk(skip == 1'b0, "R14", "skip with reset threshold", int'(skip), 0);

    // vector table
    for (int i = 0; i < 8; i++) begin
      logic [34:0] v;
      string req;
      v = VEC[i];
      if (v[34]) new_mb(int'(v[33:18]));
      send_cand(v[17:13], v[12:8], int'(v[7:0]));
      case (i)
        2: req = "R5";
        5: req = "R8";
        6, 7: req = "R9";
        default: req = "R4";
      endcase
      chk(int'(skip) == exp_skip, (i >= 6) ? "R9" : "R6", $sformatf("skip vector %0d", i),
          int'(skip), exp_skip);
      check_all(req);
    end

    // R7 / R6 threshold boundary
    cur_max = 0;
    s9 = part_sad(0, 9);
    new_mb(s9);
    send_cand(5'd0, 5'd0, 9);
    chk(skip == 1'b0, "R7", "skip at equal threshold", int'(skip), 0);
    new_mb(s9 + 1);
    send_cand(5'd0, 5'd0, 9);
    chk(skip == 1'b1, "R6", "skip just below threshold", int'(skip), 1);

    // R10 clearing
    @(negedge clk); mb_start = 1'b1;
    @(negedge clk); mb_start = 1'b0; sel = 6'd0; #1;
    chk(skip == 1'b0, "R10", "skip cleared", int'(skip), 0);
    chk(res_cost == 16'hFFFF && res_mvx == 5'd0 && res_mvy == 5'd0, "R10", "part 0 cleared",
        int'(res_cost), 65535);
    sel = 6'd25; #1;
    chk(res_cost == 16'hFFFF, "R10", "part 25 cleared", int'(res_cost), 65535);

    // R12 full range
    cur_max = 1;
    new_mb(0);
    send_cand(5'd0, 5'd0, 254);
    @(negedge clk); sel = 6'd0; #1;
    chk(int'(res_cost) == 65280, "R12", "16x16 full range", int'(res_cost), 65280);
    sel = 6'd25; #1;
    chk(int'(res_cost) == 4080, "R2", "4x4 full range", int'(res_cost), 4080);
    check_all("R12");
    cur_max = 0;

    // R13 out-of-range selector
    @(negedge clk); sel = 6'd41; #1;
    chk(res_cost == 16'hFFFF && res_mvx == 5'd0 && res_mvy == 5'd0, "R13", "sel 41",
        int'(res_cost), 65535);
    sel = 6'd63; #1;
    chk(res_cost == 16'hFFFF && res_mvx == 5'd0 && res_mvy == 5'd0, "R13", "sel 63",
        int'(res_cost), 65535);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule